// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a fast system clock into two independent streams of one-cycle enable ticks. One stream paces an infrared line coder at a fixed reference rate. The other paces a serial receiver/transmitter at sixteen times its bit rate. Each channel is set by two software-written registers. The count register holds the integer part of the divisor. The correction register holds a fraction of the divisor in sixteenths.

The fraction is met on average, not on every period. Over any run of sixteen output periods, as many periods as the fraction code gets one extra clock. A four-bit accumulator decides which periods those are, so the long periods are spaced as evenly as the code allows. Choosing the system clock and working out the register values is left to software.

Each register write restarts its own channel, so a channel's ticks are always aligned to its last write.

Top module: `frac_baud_gen`

## Requirements
- R1: With infrared count value C (1 to 15), a period of the infrared channel lasts C+1 clocks, plus one when that period is stretched. Each `ir_tick` pulse is exactly one clock high.
- R2: While the infrared count register holds zero, `ir_tick` stays low.
- R3: With UART count value U, a period of the UART channel lasts (U+1)×16 clocks, plus one when that period is stretched. Each `uart_tick` pulse is exactly one clock high.
- R4: The fraction code F is taken from bits [7:4] of the correction write data. Bits [3:0] of that data have no effect.
- R5: Periods are numbered i = 0, 1, 2, … from the last restart. Period i is stretched exactly when ((i×F) mod 16) + F ≥ 16. Over the first 16 periods this stretches exactly F of them, so the first 16 periods last 16×base+F clocks together.
- R6: A write to either register of a channel restarts that channel. The clock cycle after the write edge is cycle 0 of a fresh period 0. The first tick comes in cycle L0−1, where L0 is the length of period 0. Cycle 0 never carries a tick.
- R7: Writes to one channel's registers do not disturb the tick timing of the other channel.
- R8: After reset, all four registers are zero. `ir_tick` is then low, and `uart_tick` first fires in cycle 15 after reset is released, then every 16 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_cnt_we | input | 1 | Write strobe, infrared count register |
| ir_cnt_wdata | input | IR_CNT_W | Infrared count (divisor minus one) |
| ir_frac_we | input | 1 | Write strobe, infrared correction register |
| ir_frac_wdata | input | REG_W | Infrared correction data; fraction in [7:4] |
| uart_cnt_we | input | 1 | Write strobe, UART count register |
| uart_cnt_wdata | input | UART_CNT_W | UART count (divisor/16 minus one) |
| uart_frac_we | input | 1 | Write strobe, UART correction register |
| uart_frac_wdata | input | REG_W | UART correction data; fraction in [7:4] |
| ir_tick | output | 1 | One-clock infrared rate enable |
| uart_tick | output | 1 | One-clock 16× oversampling enable |

## Verification
The bench compares the cycle of every tick against a reference that it builds itself from the stretch rule. An accumulator seeded wrongly, or one whose carry is taken at the wrong step, puts the long periods in the wrong places. A design whose stretch count is off by one fails the 16-period total. Several edge cases get their own tests:
- The extreme fraction code 15 and the shortest infrared divisor.
- A correction write whose low nibble is set. A design that reads the wrong field would stretch periods that should stay short.
- A rewrite in the middle of a period. A design that ignores the restart fires at the old phase.
- A zero infrared count. A design that does not guard it would tick every one or two clocks.

// File: rtl/frac_baud_gen.sv
module frac_baud_gen #(
  parameter int IR_CNT_W   = 4,
  parameter int UART_CNT_W = 12,
  parameter int REG_W      = 8,
  parameter int FRAC_LSB   = 4,
  parameter int FRAC_W     = 4,
  parameter int OVS_LOG2   = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ir_cnt_we,
  input  logic [IR_CNT_W-1:0]   ir_cnt_wdata,
  input  logic                  ir_frac_we,
  input  logic [REG_W-1:0]      ir_frac_wdata,
  input  logic                  uart_cnt_we,
  input  logic [UART_CNT_W-1:0] uart_cnt_wdata,
  input  logic                  uart_frac_we,
  input  logic [REG_W-1:0]      uart_frac_wdata,
  output logic                  ir_tick,
  output logic                  uart_tick
);
  localparam int PW = UART_CNT_W + OVS_LOG2 + 1;

  logic [IR_CNT_W-1:0]   ir_cnt_q;
  logic [UART_CNT_W-1:0] uart_cnt_q;
  logic [FRAC_W-1:0]     ir_frac_q, uart_frac_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_cnt_q    <= '0;
      uart_cnt_q  <= '0;
      ir_frac_q   <= '0;
      uart_frac_q <= '0;
    end else begin
      if (ir_cnt_we)    ir_cnt_q    <= ir_cnt_wdata;
      if (uart_cnt_we)  uart_cnt_q  <= uart_cnt_wdata;
      if (ir_frac_we)   ir_frac_q   <= ir_frac_wdata[FRAC_LSB +: FRAC_W];
      if (uart_frac_we) uart_frac_q <= uart_frac_wdata[FRAC_LSB +: FRAC_W];
    end
  end

  logic [1:0]        restart, legal, tick_w;
  logic [PW-1:0]     base [2];
  logic [FRAC_W-1:0] frac [2];

  assign restart[0] = ir_cnt_we | ir_frac_we;
  assign restart[1] = uart_cnt_we | uart_frac_we;
  assign legal[0]   = |ir_cnt_q;
  assign legal[1]   = 1'b1;
  assign base[0]    = PW'(ir_cnt_q) + PW'(1);
  assign base[1]    = (PW'(uart_cnt_q) + PW'(1)) << OVS_LOG2;
  assign frac[0]    = ir_frac_q;
  assign frac[1]    = uart_frac_q;

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic [PW-1:0]     pos_q, len;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum       = {1'b0, acc_q} + {1'b0, frac[g]};
    assign len       = base[g] + PW'(sum[FRAC_W]);
    assign tick_w[g] = legal[g] && (pos_q == len - PW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pos_q <= '0;
        acc_q <= '0;
      end else if (restart[g] || !legal[g]) begin
        pos_q <= '0;
        acc_q <= '0;
      end else if (tick_w[g]) begin
        pos_q <= '0;
        acc_q <= sum[FRAC_W-1:0];
      end else begin
        pos_q <= pos_q + PW'(1);
      end
    end
  end

  assign ir_tick   = tick_w[0];
  assign uart_tick = tick_w[1];
endmodule

module frac_baud_gen_chk #(
  parameter int IR_CNT_W   = 4,
  parameter int UART_CNT_W = 12,
  parameter int FRAC_W     = 4,
  parameter int OVS_LOG2   = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ir_cnt_we,
  input logic                  ir_frac_we,
  input logic                  uart_cnt_we,
  input logic                  uart_frac_we,
  input logic                  ir_tick,
  input logic                  uart_tick,
  input logic [IR_CNT_W-1:0]   ir_cnt_q,
  input logic [UART_CNT_W-1:0] uart_cnt_q,
  input logic [FRAC_W-1:0]     ir_frac_q,
  input logic [FRAC_W-1:0]     uart_frac_q
);
  localparam int WIN = 1 << FRAC_W;

  logic ir_we, uart_we;
  assign ir_we   = ir_cnt_we | ir_frac_we;
  assign uart_we = uart_cnt_we | uart_frac_we;

  assert_ir_zero_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ir_cnt_q == '0) |-> !ir_tick);
  assert_ir_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ir_tick |=> !ir_tick);
  assert_uart_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    uart_tick |=> !uart_tick);
  assert_ir_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> !ir_tick);
  assert_uart_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    uart_we |=> !uart_tick);

  int unsigned ir_cyc, uart_cyc, ir_n, uart_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_cyc <= 0; ir_n <= 0; uart_cyc <= 0; uart_n <= 0;
    end else begin
      if (ir_we) begin
        ir_cyc <= 0; ir_n <= 0;
      end else if (ir_tick && ir_n == WIN - 1) begin
        assert_ir_window_R5: assert (ir_cyc + 1 == WIN * (int'(ir_cnt_q) + 1) + int'(ir_frac_q))
          else $error("ir window length %0d", ir_cyc + 1);
        ir_cyc <= 0; ir_n <= 0;
      end else begin
        ir_cyc <= ir_cyc + 1;
        if (ir_tick) ir_n <= ir_n + 1;
      end
      if (uart_we) begin
        uart_cyc <= 0; uart_n <= 0;
      end else if (uart_tick && uart_n == WIN - 1) begin
        assert_uart_window_R5: assert (uart_cyc + 1 ==
          WIN * ((int'(uart_cnt_q) + 1) << OVS_LOG2) + int'(uart_frac_q))
          else $error("uart window length %0d", uart_cyc + 1);
        uart_cyc <= 0; uart_n <= 0;
      end else begin
        uart_cyc <= uart_cyc + 1;
        if (uart_tick) uart_n <= uart_n + 1;
      end
    end
  end
endmodule

bind frac_baud_gen frac_baud_gen_chk #(
  .IR_CNT_W(IR_CNT_W), .UART_CNT_W(UART_CNT_W), .FRAC_W(FRAC_W), .OVS_LOG2(OVS_LOG2)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .ir_cnt_we(ir_cnt_we), .ir_frac_we(ir_frac_we),
  .uart_cnt_we(uart_cnt_we), .uart_frac_we(uart_frac_we),
  .ir_tick(ir_tick), .uart_tick(uart_tick),
  .ir_cnt_q(ir_cnt_q), .uart_cnt_q(uart_cnt_q),
  .ir_frac_q(ir_frac_q), .uart_frac_q(uart_frac_q)
);

// File: tb/frac_baud_gen_tb.sv
module frac_baud_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_cnt_we = 1'b0, ir_frac_we = 1'b0, uart_cnt_we = 1'b0, uart_frac_we = 1'b0;
  logic [3:0]  ir_cnt_wdata = '0;
  logic [11:0] uart_cnt_wdata = '0;
  logic [7:0]  ir_frac_wdata = '0, uart_frac_wdata = '0;
  logic        ir_tick, uart_tick;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  frac_baud_gen u_dut (
    .clk(clk), .rst_n(rst_n),
    .ir_cnt_we(ir_cnt_we), .ir_cnt_wdata(ir_cnt_wdata),
    .ir_frac_we(ir_frac_we), .ir_frac_wdata(ir_frac_wdata),
    .uart_cnt_we(uart_cnt_we), .uart_cnt_wdata(uart_cnt_wdata),
    .uart_frac_we(uart_frac_we), .uart_frac_wdata(uart_frac_wdata),
    .ir_tick(ir_tick), .uart_tick(uart_tick)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int plen(input int base, input int f, input int i);
    int acc = (i * f) % 16;
    return base + (((acc + f) >= 16) ? 1 : 0);
  endfunction

  // Starts at a negedge; writes both registers of a channel, then follows nper periods.
  task automatic run_ch(input int ch, input int cnt, input int fbyte, input int nper, input string tag);
    int base, f, nxt, i, err, c, c16;
    f = (fbyte >> 4) & 15;
    base = (ch == 0) ? cnt + 1 : (cnt + 1) * 16;
    if (ch == 0) begin
      ir_cnt_wdata = 4'(cnt); ir_frac_wdata = 8'(fbyte); ir_cnt_we = 1; ir_frac_we = 1;
    end else begin
      uart_cnt_wdata = 12'(cnt); uart_frac_wdata = 8'(fbyte); uart_cnt_we = 1; uart_frac_we = 1;
    end
    @(negedge clk);
    ir_cnt_we = 0; ir_frac_we = 0; uart_cnt_we = 0; uart_frac_we = 0;
    nxt = plen(base, f, 0) - 1; i = 0; err = 0; c = 0; c16 = -1;
    while (i < nper) begin
      bit t = (ch == 0) ? ir_tick : uart_tick;
      bit e = (c == nxt);
      if (t != e) err++;
      if (e) begin
        i++;
        if (i == 16) c16 = c;
        nxt += plen(base, f, i);
      end
      c++;
      @(negedge clk);
    end
    check(err == 0, {tag, " tick cycles"}, err, 0);
    if (nper >= 16) check(c16 + 1 == 16 * base + f, "R5 window total", c16 + 1, 16 * base + f);
  endtask

  task automatic t_reset();
    int err = 0;
    check(ir_tick == 0, "R8 ir_tick after reset", ir_tick, 0);
    for (int c = 0; c < 64; c++) begin
      if (uart_tick != ((c % 16) == 15)) err++;
      if (ir_tick) err++;
      @(negedge clk);
    end
    check(err == 0, "R8 reset tick pattern", err, 0);
  endtask

  task automatic t_ir_zero();
    int hits = 0;
    ir_cnt_wdata = 0; ir_frac_wdata = 8'h70; ir_cnt_we = 1; ir_frac_we = 1;
    @(negedge clk);
    ir_cnt_we = 0; ir_frac_we = 0;
    for (int c = 0; c < 100; c++) begin
      if (ir_tick) hits++;
      @(negedge clk);
    end
    check(hits == 0, "R2 zero count holds ir_tick low", hits, 0);
  endtask

  task automatic t_restart();
    int err = 0;
    ir_cnt_wdata = 7; ir_frac_wdata = 0; ir_cnt_we = 1; ir_frac_we = 1;
    @(negedge clk);
    ir_cnt_we = 0; ir_frac_we = 0;
    repeat (5) @(negedge clk);
    ir_frac_we = 1;
    @(negedge clk);
    ir_frac_we = 0;
    for (int c = 0; c < 8; c++) begin
      if (ir_tick != (c == 7)) err++;
      @(negedge clk);
    end
    check(err == 0, "R6 mid-period rewrite realigns", err, 0);
  endtask

  task automatic t_indep();
    int err = 0;
    uart_cnt_wdata = 0; uart_frac_wdata = 0; uart_cnt_we = 1; uart_frac_we = 1;
    @(negedge clk);
    uart_cnt_we = 0; uart_frac_we = 0;
    for (int c = 0; c < 200; c++) begin
      ir_cnt_wdata = 4'(1 + c % 5);
      ir_cnt_we = ((c % 10) == 3);
      ir_frac_we = ((c % 7) == 2);
      if (uart_tick != ((c % 16) == 15)) err++;
      @(negedge clk);
    end
    ir_cnt_we = 0; ir_frac_we = 0;
    check(err == 0, "R7 uart undisturbed by ir writes", err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    run_ch(0, 3, 8'h00, 20, "R1 ir integer");
    run_ch(0, 1, 8'h50, 40, "R5 ir frac 5");
    run_ch(0, 15, 8'hF0, 32, "R5 ir frac 15");
    run_ch(0, 2, 8'h0F, 16, "R4 low nibble ignored");
    run_ch(0, 2, 8'h3A, 16, "R4 field [7:4]");
    run_ch(1, 2, 8'h90, 20, "R3 uart frac 9");
    run_ch(1, 0, 8'h10, 16, "R3 uart min divisor");
    t_ir_zero();
    t_restart();
    t_indep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule